// File: doc/BRIEF.md
# Ping-Pong DMA Channel

This block is a single DMA channel with two transfer descriptors. Each descriptor has a start address and a byte count. Software loads and arms one descriptor while the channel moves data for the other. When the active descriptor runs out, the channel goes straight on to the other one if that one is armed, so a stream never stalls between buffers. A peripheral asks for data with a request line. For each transfer beat, the channel makes one access on a simple memory port and returns a one-cycle acknowledge.

All control goes through a small word-addressed register port. The 8-bit status word has three views:

- a read view;
- a set view, where each 1 written sets that bit;
- a clear view, where each 1 written clears that bit.

Software can therefore change single bits without a read-modify-write. A selector bit in the status word shows which descriptor is active, and only the hardware can change it. An interrupt line reports completed descriptors. A sticky fault bit records any access that the memory port rejected.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset the status word, the device word and all four descriptor registers read 0. The selector points at descriptor A, and `irq`, `mem_en` and `dack` are low.
- R2: Register offsets are 0 status read view, 1 set view, 2 clear view, 3 device word, 4 A address, 5 A count, 6 B address, 7 B count. Status bits are 0 go, 1 irq enable, 2 arm A, 3 arm B, 4 finished A, 5 finished B, 6 selector (1 = B) and 7 fault. A 1 in the set view sets a bit, and a 1 in the clear view clears it. Zero bits leave bits unchanged, and writes to bit 6 are ignored.
- R3: `irq` is high exactly while the irq enable bit is set and at least one finished bit is set.
- R4: A beat happens in a cycle where go is set, the active descriptor is armed, its count is nonzero and `dreq` is high. In that cycle `mem_en` is high and `mem_addr` shows the active address. `dack` is high for exactly the cycle after each beat.
- R5: Each beat adds 4 to the active address and takes 4 from its count (a count of 4 or less becomes 0). Reading the address register during a transfer shows the current position.
- R6: When an armed active descriptor reaches count 0, its arm bit clears and its finished bit sets. A descriptor armed with count 0 finishes this way without any memory access.
- R7: If the other descriptor is armed when the active one finishes, the selector flips on the same edge and the next beat follows with no idle cycle. If the active descriptor is unarmed while the other is armed, the selector flips on the next edge.
- R8: Clearing go stops beats at the next beat boundary and keeps the address and count. Setting go again carries on from where the transfer stopped.
- R9: A beat with `mem_err` high sets the fault bit. The fault bit stays set until software clears it through the clear view.
- R10: Count registers hold 13 bits, so the largest count is 0x1FFF. The device word drives `mem_dev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | One-cycle acknowledge, one cycle after each beat |
| mem_en | output | 1 | Memory access strobe, one per beat |
| mem_addr | output | 32 | Memory address of the current beat |
| mem_dev | output | 32 | Peripheral device word |
| mem_err | input | 1 | Memory port fault for the current beat |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is the hand-over with no gap. Descriptor A must run down to zero while B is already armed and the peripheral keeps its request high, so that the beat after A's last beat lands on B's first address in the very next cycle. The bench arms both descriptors with short counts before raising the request, and then checks the address of every cycle.

Two further cases need careful timing:
- Halting between beats: the go bit is cleared in the same cycle as a beat. The bench then checks that the address and count stay where they are over several idle cycles.
- The idle selector flip: a descriptor is armed while the selector still points at a finished one.

// File: rtl/pp_dma_pkg.sv
`timescale 1ns/1ps
package pp_dma_pkg;

  localparam int ST_W = 8;

  // status word bit positions
  localparam int ST_GO   = 0;
  localparam int ST_IE   = 1;
  localparam int ST_ARM0 = 2;
  localparam int ST_ARM1 = 3;
  localparam int ST_FIN0 = 4;
  localparam int ST_FIN1 = 5;
  localparam int ST_SEL  = 6;
  localparam int ST_FLT  = 7;

  // register word offsets
  localparam logic [2:0] RA_STAT = 3'd0;
  localparam logic [2:0] RA_SET  = 3'd1;
  localparam logic [2:0] RA_CLR  = 3'd2;
  localparam logic [2:0] RA_DEV  = 3'd3;
  localparam logic [2:0] RA_AADR = 3'd4;
  localparam logic [2:0] RA_ACNT = 3'd5;
  localparam logic [2:0] RA_BADR = 3'd6;
  localparam logic [2:0] RA_BCNT = 3'd7;

endpackage

// File: rtl/pp_dma_desc.sv
`timescale 1ns/1ps
module pp_dma_desc #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int STEP   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             addr_we,
  input  logic [1:0]             cnt_we,
  input  logic [DATA_W-1:0]      wdata,
  input  logic                   adv,
  input  logic                   sel,
  output logic [1:0][ADDR_W-1:0] addr_q,
  output logic [1:0][CNT_W-1:0]  cnt_q
);

  localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(STEP);
  localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(STEP);

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + ASTEP;
  endfunction

  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c);
    return (c <= CSTEP) ? '0 : c - CSTEP;
  endfunction

  for (genvar i = 0; i < 2; i++) begin : g_slot
    logic mine;
    assign mine = adv && (sel == 1'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
      end else begin
        if (addr_we[i])
          addr_q[i] <= wdata[ADDR_W-1:0];
        else if (mine)
          addr_q[i] <= step_addr(addr_q[i]);
        if (cnt_we[i])
          cnt_q[i] <= wdata[CNT_W-1:0];
        else if (mine)
          cnt_q[i] <= step_cnt(cnt_q[i]);
      end
    end
  end

endmodule

// File: rtl/pp_dma_beat.sv
`timescale 1ns/1ps
module pp_dma_beat #(
  parameter int CNT_W = 13,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             arm_act,
  input  logic             dreq,
  input  logic [CNT_W-1:0] cnt_act,
  output logic             beat,
  output logic             finish,
  output logic             dack
);

  localparam logic [CNT_W-1:0] CSTEP = CNT_W'(STEP);

  function automatic logic last_chunk(input logic [CNT_W-1:0] c);
    return (c != '0) && (c <= CSTEP);
  endfunction

  logic live;
  assign live   = go && arm_act;
  assign beat   = live && dreq && (cnt_act != '0);
  assign finish = live && ((cnt_act == '0) || (beat && last_chunk(cnt_act)));

  always_ff @(posedge clk) begin
    if (!rst_n) dack <= 1'b0;
    else        dack <= beat;
  end

endmodule

// File: rtl/pp_dma_csr.sv
`timescale 1ns/1ps
module pp_dma_csr
  import pp_dma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [ST_W-1:0] wbits,
  input  logic            finish,
  input  logic            fault,
  output logic [ST_W-1:0] status
);

  localparam logic [ST_W-1:0] SW_MASK = ~(ST_W'(1) << ST_SEL);

  function automatic logic hop(input logic [1:0] arm, input logic sel, input logic fin);
    if (fin) return arm[~sel];
    return !arm[sel] && arm[~sel];
  endfunction

  logic [ST_W-1:0] st_q, nxt;
  logic            cur_sel;
  logic [1:0]      arm;

  assign cur_sel = st_q[ST_SEL];
  assign arm     = {st_q[ST_ARM1], st_q[ST_ARM0]};

  always_comb begin
    nxt = st_q;
    if (set_we) nxt = nxt | (wbits & SW_MASK);
    if (clr_we) nxt = nxt & ~(wbits & SW_MASK);
    if (finish) begin
      if (cur_sel) begin
        nxt[ST_ARM1] = 1'b0;
        nxt[ST_FIN1] = 1'b1;
      end else begin
        nxt[ST_ARM0] = 1'b0;
        nxt[ST_FIN0] = 1'b1;
      end
    end
    nxt[ST_SEL] = cur_sel ^ hop(arm, cur_sel, finish);
    if (fault) nxt[ST_FLT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= nxt;
  end

  assign status = st_q;

endmodule

// File: rtl/pp_dma_chan.sv
`timescale 1ns/1ps
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dreq,
  output logic              dack,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dev,
  input  logic              mem_err,
  output logic              irq
);

  logic [ST_W-1:0]        status_w;
  logic                   set_we, clr_we;
  logic [1:0]             addr_we, cnt_we;
  logic [1:0][ADDR_W-1:0] addr_q;
  logic [1:0][CNT_W-1:0]  cnt_q;
  logic                   sel_w, arm_act, beat_w, finish_w, fault_w;
  logic [DATA_W-1:0]      dev_q;

  assign set_we  = reg_we && (reg_addr == RA_SET);
  assign clr_we  = reg_we && (reg_addr == RA_CLR);
  assign addr_we = {reg_we && (reg_addr == RA_BADR), reg_we && (reg_addr == RA_AADR)};
  assign cnt_we  = {reg_we && (reg_addr == RA_BCNT), reg_we && (reg_addr == RA_ACNT)};

  always_ff @(posedge clk) begin
    if (!rst_n)                             dev_q <= '0;
    else if (reg_we && reg_addr == RA_DEV)  dev_q <= reg_wdata;
  end

  assign sel_w   = status_w[ST_SEL];
  assign arm_act = sel_w ? status_w[ST_ARM1] : status_w[ST_ARM0];
  assign fault_w = beat_w && mem_err;

  pp_dma_csr csr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (set_we),
    .clr_we (clr_we),
    .wbits  (reg_wdata[ST_W-1:0]),
    .finish (finish_w),
    .fault  (fault_w),
    .status (status_w)
  );

  pp_dma_desc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .STEP(STEP)) desc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (addr_we),
    .cnt_we  (cnt_we),
    .wdata   (reg_wdata),
    .adv     (beat_w),
    .sel     (sel_w),
    .addr_q  (addr_q),
    .cnt_q   (cnt_q)
  );

  pp_dma_beat #(.CNT_W(CNT_W), .STEP(STEP)) beat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (status_w[ST_GO]),
    .arm_act (arm_act),
    .dreq    (dreq),
    .cnt_act (cnt_q[sel_w]),
    .beat    (beat_w),
    .finish  (finish_w),
    .dack    (dack)
  );

  assign mem_en   = beat_w;
  assign mem_addr = addr_q[sel_w];
  assign mem_dev  = dev_q;
  assign irq      = status_w[ST_IE] && (status_w[ST_FIN0] || status_w[ST_FIN1]);

  always_comb begin
    case (reg_addr)
      RA_STAT: reg_rdata = DATA_W'(status_w);
      RA_DEV:  reg_rdata = dev_q;
      RA_AADR: reg_rdata = DATA_W'(addr_q[0]);
      RA_ACNT: reg_rdata = DATA_W'(cnt_q[0]);
      RA_BADR: reg_rdata = DATA_W'(addr_q[1]);
      RA_BCNT: reg_rdata = DATA_W'(cnt_q[1]);
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pp_dma_chk.sv
`timescale 1ns/1ps
module pp_dma_chk
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [7:0]        reg_wbits,
  input logic              dreq,
  input logic              dack,
  input logic              mem_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_err,
  input logic              irq,
  input logic [ST_W-1:0]   status,
  input logic              finish_w
);

  logic arm_act, clr_flt, clr_ie;
  assign arm_act = status[ST_SEL] ? status[ST_ARM1] : status[ST_ARM0];
  assign clr_flt = reg_we && (reg_addr == RA_CLR) && reg_wbits[ST_FLT];
  assign clr_ie  = reg_we && (reg_addr == RA_CLR) && reg_wbits[ST_IE];

  assert_beat_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (status[ST_GO] && arm_act && dreq));

  assert_ack_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> dack);

  assert_no_stray_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_en |=> !dack);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !finish_w && !reg_we) |=> (!mem_en || mem_addr == $past(mem_addr) + ADDR_W'(STEP)));

  assert_finish_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_w && !reg_we) |=> (status[ST_FIN0] || status[ST_FIN1]));

  assert_sel_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_SEL] != $past(status[ST_SEL])) |-> $past(finish_w || !arm_act));

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !status[ST_GO] |-> !mem_en);

  assert_irq_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ie |=> !irq);

  assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_err) |=> status[ST_FLT]);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_FLT] && !clr_flt) |=> status[ST_FLT]);

endmodule

bind pp_dma_chan pp_dma_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wbits (reg_wdata[7:0]),
  .dreq      (dreq),
  .dack      (dack),
  .mem_en    (mem_en),
  .mem_addr  (mem_addr),
  .mem_err   (mem_err),
  .irq       (irq),
  .status    (status_w),
  .finish_w  (finish_w)
);

// File: tb/pp_dma_chan_tb_top.sv
`timescale 1ns/1ps
module pp_dma_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dreq = 1'b0;
  logic        dack;
  logic        mem_en;
  logic [31:0] mem_addr;
  logic [31:0] mem_dev;
  logic        mem_err = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pp_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_dev(mem_dev),
    .mem_err(mem_err), .irq(irq)
  );

  // {offset, write bits, expected status, expected irq}
  localparam logic [19:0] VEC [0:8] = '{
    {3'd1, 8'h02, 8'h02, 1'b0},
    {3'd1, 8'h10, 8'h12, 1'b1},
    {3'd2, 8'h02, 8'h10, 1'b0},
    {3'd1, 8'h21, 8'h31, 1'b0},
    {3'd2, 8'h31, 8'h00, 1'b0},
    {3'd1, 8'h40, 8'h00, 1'b0},
    {3'd1, 8'h80, 8'h80, 1'b0},
    {3'd2, 8'h00, 8'h80, 1'b0},
    {3'd2, 8'h80, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.25;
    d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_en", 32'(mem_en), 0);
    chk("R1 dack", 32'(dack), 0);
    for (int a = 0; a < 8; a++) chk_reg("R1 reg", 3'(a), 0);

    // R10 device word
    wr(3'd3, 32'hABCD0123);
    chk("R10 mem_dev", mem_dev, 32'hABCD0123);

    // R2 / R3 alias table
    for (int i = 0; i < 9; i++) begin
      logic [31:0] v;
      wr(VEC[i][19:17], 32'(VEC[i][16:9]));
      rd(3'd0, v);
      chk("R2 status alias", v, 32'(VEC[i][8:1]));
      chk("R3 irq", 32'(irq), 32'(VEC[i][0]));
    end

    // R4 R5 R6 single transfer on A
    wr(3'd4, 32'h1000); wr(3'd5, 12); wr(3'd1, 32'h07);
    chk_reg("R4 armed", 3'd0, 32'h07);
    chk("R4 no req no beat", 32'(mem_en), 0);
    dreq = 1'b1; #0.25;
    chk("R4 beat", 32'(mem_en), 1);
    chk("R4 addr0", mem_addr, 32'h1000);
    chk("R4 ack late", 32'(dack), 0);
    @(negedge clk);
    chk("R5 addr1", mem_addr, 32'h1004);
    chk("R4 ack", 32'(dack), 1);
    chk_reg("R5 live addr", 3'd4, 32'h1004);
    chk_reg("R5 live count", 3'd5, 8);
    @(negedge clk);
    chk("R5 addr2", mem_addr, 32'h1008);
    @(negedge clk);
    chk("R6 stop after last", 32'(mem_en), 0);
    chk("R4 last ack", 32'(dack), 1);
    chk_reg("R6 status", 3'd0, 32'h13);
    chk("R3 irq done", 32'(irq), 1);
    chk_reg("R5 end addr", 3'd4, 32'h100C);
    chk_reg("R6 end count", 3'd5, 0);
    dreq = 1'b0;
    @(negedge clk);
    chk("R4 ack one cycle", 32'(dack), 0);

    // R7 ping-pong hand-over with no gap
    wr(3'd2, 32'h10);
    wr(3'd4, 32'h2000); wr(3'd5, 8); wr(3'd6, 32'h3000); wr(3'd7, 8);
    wr(3'd1, 32'h0C);
    chk_reg("R7 both armed", 3'd0, 32'h0F);
    dreq = 1'b1; #0.25;
    chk("R7 a0", mem_addr, 32'h2000);
    @(negedge clk); chk("R7 a1", mem_addr, 32'h2004);
    @(negedge clk);
    chk("R7 no gap", 32'(mem_en), 1);
    chk("R7 b0", mem_addr, 32'h3000);
    @(negedge clk); chk("R7 b1", mem_addr, 32'h3004);
    @(negedge clk);
    chk("R7 idle", 32'(mem_en), 0);
    chk_reg("R7 status", 3'd0, 32'h73);
    dreq = 1'b0;
    wr(3'd2, 32'h30);
    chk_reg("R2 fin clear", 3'd0, 32'h43);

    // R7 idle flip, R8 halt and resume
    wr(3'd4, 32'h4000); wr(3'd5, 16); wr(3'd1, 32'h04);
    chk_reg("R7 before flip", 3'd0, 32'h47);
    @(negedge clk);
    chk_reg("R7 idle flip", 3'd0, 32'h07);
    dreq = 1'b1; #0.25;
    chk("R8 beat0", mem_addr, 32'h4000);
    wr(3'd2, 32'h01);
    chk("R8 halted", 32'(mem_en), 0);
    chk_reg("R8 status", 3'd0, 32'h06);
    repeat (3) @(negedge clk);
    chk("R8 still halted", 32'(mem_en), 0);
    chk("R8 no ack", 32'(dack), 0);
    chk_reg("R8 addr kept", 3'd4, 32'h4004);
    chk_reg("R8 count kept", 3'd5, 12);
    wr(3'd1, 32'h01);
    chk("R8 resume", mem_addr, 32'h4004);
    chk("R8 resume beat", 32'(mem_en), 1);
    @(negedge clk); chk("R8 r1", mem_addr, 32'h4008);
    @(negedge clk); chk("R8 r2", mem_addr, 32'h400C);
    @(negedge clk);
    chk("R8 done", 32'(mem_en), 0);
    chk_reg("R8 fin", 3'd0, 32'h13);

    // R9 fault
    wr(3'd2, 32'h10);
    chk_reg("R9 pre", 3'd0, 32'h03);
    wr(3'd4, 32'h5000); wr(3'd5, 4);
    mem_err = 1'b1;
    chk_reg("R9 no beat no fault", 3'd0, 32'h03);
    wr(3'd1, 32'h04);
    chk("R9 beat", mem_addr, 32'h5000);
    @(negedge clk);
    mem_err = 1'b0;
    chk_reg("R9 fault set", 3'd0, 32'h93);
    repeat (2) @(negedge clk);
    chk_reg("R9 fault held", 3'd0, 32'h93);
    wr(3'd2, 32'h10);
    chk_reg("R9 fault survives", 3'd0, 32'h83);
    wr(3'd2, 32'h80);
    chk_reg("R9 fault cleared", 3'd0, 32'h03);

    // R10 count width, R5 odd count, R6 zero count
    dreq = 1'b0;
    wr(3'd7, 32'hFFFFFFFF);
    chk_reg("R10 count max", 3'd7, 32'h1FFF);
    wr(3'd6, 32'h6000); wr(3'd7, 6); wr(3'd1, 32'h08);
    @(negedge clk);
    chk_reg("R7 flip to B", 3'd0, 32'h4B);
    dreq = 1'b1; #0.25;
    chk("R5 odd b0", mem_addr, 32'h6000);
    @(negedge clk); chk("R5 odd b1", mem_addr, 32'h6004);
    @(negedge clk);
    chk("R5 odd end", 32'(mem_en), 0);
    chk_reg("R6 B fin", 3'd0, 32'h63);
    chk_reg("R5 odd count", 3'd7, 0);
    chk_reg("R5 odd addr", 3'd6, 32'h6008);
    wr(3'd2, 32'h20);
    wr(3'd1, 32'h08);
    chk("R6 zero no beat", 32'(mem_en), 0);
    @(negedge clk);
    chk("R6 zero no access", 32'(mem_en), 0);
    chk("R6 zero no ack", 32'(dack), 0);
    chk_reg("R6 zero fin", 3'd0, 32'h63);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule